// File: doc/BRIEF.md
# Boundary-Scan Instruction and Bypass Register Unit

This block sits beside a test access port controller and holds the instruction that governs a boundary-scan chain. An 8-bit instruction shift stage is loaded with a fixed capture pattern and shifted serially from `tdi`. The active instruction stage takes a copy of the shift stage only on the update strobe. The block has no identification register. The fixed capture pattern therefore serves as a pseudo-identifier: a tester can read it out to confirm which device sits at a given position in the chain.

A one-bit bypass stage gives the shortest data path through the device. The active instruction is decoded into a data-register select and into four mode flags for the boundary-scan cells: external test, sample, clamp and high impedance. A separate override flag tells the core when the boundary cells, and not the core, drive the outputs. Any opcode without a defined meaning acts as bypass.

The TAP state machine is outside this block. It supplies one strobe per relevant state on every rising edge of `tck`. This block uses those strobes to load, shift and update its registers.

Top module: `scan_instr_unit`

## Requirements
- R1: While `tlrIn` is high at a rising edge, the active instruction becomes 8'hFF (a bypass code), the shift stage becomes the capture pattern and the bypass stage becomes 0. After that edge `selBypass`=1 and all mode flags and `testOverride` are 0.
- R2: `capIrIn` at an edge loads the shift stage with 8'b00111101 (bit 7 down to bit 0), so `irSo` is 1 after that edge.
- R3: `shIrIn` at an edge shifts the instruction stage one place toward bit 0. Bit 7 takes `tdi`. `irSo` always shows bit 0 of the shift stage, so the capture pattern leaves LSB first.
- R4: The active instruction, and with it every decoded output, changes only at an edge with `updIrIn` (or `tlrIn`). At an update edge it takes the shift stage contents.
- R5: Opcode 8'h00 (external test) gives `selBypass`=0, `modeExtest`=1 and `testOverride`=1.
- R6: Opcode 8'h81 (sample/preload) gives `selBypass`=0, `modeSample`=1 and `testOverride`=0.
- R7: Opcode 8'h82 (clamp) gives `selBypass`=1, `modeClamp`=1 and `testOverride`=1.
- R8: Opcode 8'h03 (high impedance) gives `selBypass`=1, `modeHighz`=1 and `testOverride`=1.
- R9: Every other opcode gives `selBypass`=1, with all four mode flags and `testOverride` at 0. At most one mode flag is ever high.
- R10: `capDrIn` at an edge loads the bypass stage with 0. `shDrIn` at an edge loads it with `tdi`. `bypSo` shows the bypass stage.
- R11: `tlrIn` takes precedence over every other strobe that is high at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all registers change on its rising edge |
| tlrIn | input | 1 | High while the TAP is in test-logic-reset |
| capIrIn | input | 1 | High in the capture-IR state |
| shIrIn | input | 1 | High in the shift-IR state |
| updIrIn | input | 1 | High in the update-IR state |
| capDrIn | input | 1 | High in the capture-DR state |
| shDrIn | input | 1 | High in the shift-DR state |
| tdi | input | 1 | Serial test data in |
| irSo | output | 1 | Serial output of the instruction shift stage (bit 0) |
| bypSo | output | 1 | Serial output of the bypass stage |
| selBypass | output | 1 | 1 selects the bypass stage, 0 selects the boundary-scan chain |
| modeExtest | output | 1 | External test instruction active |
| modeSample | output | 1 | Sample/preload instruction active |
| modeClamp | output | 1 | Clamp instruction active |
| modeHighz | output | 1 | High-impedance instruction active |
| testOverride | output | 1 | Boundary cells, not the core, control the outputs |

## Verification
Every result appears one rising edge after the strobe that causes it. The decode outputs are combinational from the active stage, so they move at the same edge that updates the active stage. The bench therefore drives each strobe and `tdi` 1 ns after a rising edge and waits for the next rising edge. It then compares all outputs 1 ns later, against a model updated for that same edge, before it drives the next inputs. During shifting the bench checks every cycle that the decoded outputs have not moved.

// File: rtl/scan_ir_pkg.sv
package scan_ir_pkg;

  localparam int IR_W = 8;

  typedef logic [IR_W-1:0] opcode_t;

  localparam opcode_t CAPTURE_PAT = 8'b0011_1101;
  localparam opcode_t OP_EXTEST   = 8'h00;
  localparam opcode_t OP_SAMPLE   = 8'h81;
  localparam opcode_t OP_CLAMP    = 8'h82;
  localparam opcode_t OP_HIGHZ    = 8'h03;
  localparam opcode_t OP_RESET    = 8'hFF;

  typedef struct packed {
    logic tlr;
    logic capIr;
    logic shIr;
    logic updIr;
    logic capDr;
    logic shDr;
  } strobe_t;

  typedef enum logic [2:0] {
    K_BYPASS,
    K_EXTEST,
    K_SAMPLE,
    K_CLAMP,
    K_HIGHZ
  } instr_kind_e;

  typedef struct packed {
    logic selBypass;
    logic extest;
    logic sample;
    logic clamp;
    logic highz;
    logic override;
  } mode_t;

endpackage

// File: rtl/scan_ir_ctrl.sv
module scan_ir_ctrl
  import scan_ir_pkg::*;
#(
  parameter opcode_t EXTEST_OP = OP_EXTEST,
  parameter opcode_t SAMPLE_OP = OP_SAMPLE,
  parameter opcode_t CLAMP_OP  = OP_CLAMP,
  parameter opcode_t HIGHZ_OP  = OP_HIGHZ
) (
  input  logic    tck,
  input  logic    tlrIn,
  input  logic    capIrIn,
  input  logic    shIrIn,
  input  logic    updIrIn,
  input  logic    capDrIn,
  input  logic    shDrIn,
  input  opcode_t activeInstr,
  output strobe_t stb,
  output mode_t   mode
);

  instr_kind_e kind;

  // Test-logic-reset masks everything; capture wins over shift
  always_comb begin
    stb.tlr   = tlrIn;
    stb.capIr = capIrIn & ~tlrIn;
    stb.shIr  = shIrIn & ~tlrIn & ~capIrIn;
    stb.updIr = updIrIn & ~tlrIn;
    stb.capDr = capDrIn & ~tlrIn;
    stb.shDr  = shDrIn & ~tlrIn & ~capDrIn;
  end

  always_comb begin
    if (activeInstr == EXTEST_OP)      kind = K_EXTEST;
    else if (activeInstr == SAMPLE_OP) kind = K_SAMPLE;
    else if (activeInstr == CLAMP_OP)  kind = K_CLAMP;
    else if (activeInstr == HIGHZ_OP)  kind = K_HIGHZ;
    else                               kind = K_BYPASS;
  end

  always_comb begin
    mode = '0;
    unique case (kind)
      K_EXTEST: begin
        mode.extest   = 1'b1;
        mode.override = 1'b1;
      end
      K_SAMPLE: begin
        mode.sample   = 1'b1;
      end
      K_CLAMP: begin
        mode.selBypass = 1'b1;
        mode.clamp     = 1'b1;
        mode.override  = 1'b1;
      end
      K_HIGHZ: begin
        mode.selBypass = 1'b1;
        mode.highz     = 1'b1;
        mode.override  = 1'b1;
      end
      default: begin
        mode.selBypass = 1'b1;
      end
    endcase
  end

  // R9: the mode flags never overlap
  a_r9_modes_exclusive: assert property (@(posedge tck) disable iff (tlrIn)
    $onehot0({mode.extest, mode.sample, mode.clamp, mode.highz}));

  // R5/R6: boundary-chain instructions never select bypass
  a_r5_boundary_selected: assert property (@(posedge tck) disable iff (tlrIn)
    (mode.extest || mode.sample) |-> !mode.selBypass);

  // R11: reset wins over any coincident strobe
  a_r11_reset_masks: assert property (@(posedge tck)
    tlrIn |-> !(stb.capIr || stb.shIr || stb.updIr || stb.capDr || stb.shDr));

endmodule

// File: rtl/scan_ir_datapath.sv
module scan_ir_datapath
  import scan_ir_pkg::*;
#(
  parameter int      W       = IR_W,
  parameter opcode_t CAP_VAL = CAPTURE_PAT,
  parameter opcode_t RST_OP  = OP_RESET
) (
  input  logic    tck,
  input  strobe_t stb,
  input  logic    tdi,
  output opcode_t activeInstr,
  output logic    irSo,
  output logic    bypSo
);

  localparam int MSB = W - 1;

  opcode_t shiftQ;
  opcode_t shiftNext;
  opcode_t activeQ;
  logic    bypQ;

  // Serial path: bit MSB takes tdi, every other bit takes its upper neighbour
  for (genvar i = 0; i < W; i++) begin : g_shift
    if (i == MSB) begin : g_top
      assign shiftNext[i] = tdi;
    end else begin : g_mid
      assign shiftNext[i] = shiftQ[i+1];
    end
  end

  always_ff @(posedge tck) begin
    if (stb.tlr) begin
      shiftQ  <= CAP_VAL;
      activeQ <= RST_OP;
      bypQ    <= 1'b0;
    end else begin
      if (stb.capIr)     shiftQ <= CAP_VAL;
      else if (stb.shIr) shiftQ <= shiftNext;
      if (stb.updIr)     activeQ <= shiftQ;
      if (stb.capDr)     bypQ <= 1'b0;
      else if (stb.shDr) bypQ <= tdi;
    end
  end

  assign activeInstr = activeQ;
  assign irSo        = shiftQ[0];
  assign bypSo       = bypQ;

  // R1: leaving reset, the active stage holds the reset opcode
  a_r1_reset_opcode: assert property (@(posedge tck)
    (!stb.tlr && $past(stb.tlr)) |-> activeQ == RST_OP);

  // R2: capture loads the fixed pattern
  a_r2_capture: assert property (@(posedge tck) disable iff (stb.tlr)
    stb.capIr |=> shiftQ == CAP_VAL);

  // R3: shift moves one place toward bit 0 with tdi entering at the top
  a_r3_shift: assert property (@(posedge tck) disable iff (stb.tlr)
    stb.shIr |=> (shiftQ[MSB] == $past(tdi)) && (shiftQ[MSB-1:0] == $past(shiftQ[MSB:1])));

  // R4: active instruction is held without an update strobe
  a_r4_hold: assert property (@(posedge tck) disable iff (stb.tlr)
    !stb.updIr |=> $stable(activeQ));

  // R10: bypass captures zero
  a_r10_bypass_capture: assert property (@(posedge tck) disable iff (stb.tlr)
    stb.capDr |=> !bypQ);

endmodule

// File: rtl/scan_instr_unit.sv
module scan_instr_unit
  import scan_ir_pkg::*;
(
  input  logic tck,
  input  logic tlrIn,
  input  logic capIrIn,
  input  logic shIrIn,
  input  logic updIrIn,
  input  logic capDrIn,
  input  logic shDrIn,
  input  logic tdi,
  output logic irSo,
  output logic bypSo,
  output logic selBypass,
  output logic modeExtest,
  output logic modeSample,
  output logic modeClamp,
  output logic modeHighz,
  output logic testOverride
);

  strobe_t stb;
  mode_t   mode;
  opcode_t activeInstr;

  scan_ir_ctrl u_ctrl (
    .tck         (tck),
    .tlrIn       (tlrIn),
    .capIrIn     (capIrIn),
    .shIrIn      (shIrIn),
    .updIrIn     (updIrIn),
    .capDrIn     (capDrIn),
    .shDrIn      (shDrIn),
    .activeInstr (activeInstr),
    .stb         (stb),
    .mode        (mode)
  );

  scan_ir_datapath u_dp (
    .tck         (tck),
    .stb         (stb),
    .tdi         (tdi),
    .activeInstr (activeInstr),
    .irSo        (irSo),
    .bypSo       (bypSo)
  );

  assign selBypass    = mode.selBypass;
  assign modeExtest   = mode.extest;
  assign modeSample   = mode.sample;
  assign modeClamp    = mode.clamp;
  assign modeHighz    = mode.highz;
  assign testOverride = mode.override;

endmodule

// File: tb/scan_instr_unit_test.sv
module scan_instr_unit_test;

  logic tck = 1'b0;
  logic tlrIn = 1'b1, capIrIn = 1'b0, shIrIn = 1'b0, updIrIn = 1'b0;
  logic capDrIn = 1'b0, shDrIn = 1'b0, tdi = 1'b0;
  logic irSo, bypSo, selBypass, modeExtest, modeSample, modeClamp, modeHighz, testOverride;

  int total = 0;
  int bad = 0;

  logic [7:0] mShift = 8'b0011_1101;
  logic [7:0] mActive = 8'hFF;
  logic       mByp = 1'b0;

  always #5 tck = ~tck;

  scan_instr_unit uut (
    .tck(tck), .tlrIn(tlrIn), .capIrIn(capIrIn), .shIrIn(shIrIn), .updIrIn(updIrIn),
    .capDrIn(capDrIn), .shDrIn(shDrIn), .tdi(tdi), .irSo(irSo), .bypSo(bypSo),
    .selBypass(selBypass), .modeExtest(modeExtest), .modeSample(modeSample),
    .modeClamp(modeClamp), .modeHighz(modeHighz), .testOverride(testOverride)
  );

  // {selBypass, extest, sample, clamp, highz, override} from R5..R9
  function automatic logic [5:0] expModes(input logic [7:0] op);
    case (op)
      8'h00:   return 6'b010001;
      8'h81:   return 6'b001000;
      8'h82:   return 6'b100101;
      8'h03:   return 6'b100011;
      default: return 6'b100000;
    endcase
  endfunction

  function automatic string tagFor(input logic [7:0] op);
    case (op)
      8'h00:   return "R5";
      8'h81:   return "R6";
      8'h82:   return "R7";
      8'h03:   return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkModes(input string tag);
    check(tag, {2'b0, selBypass, modeExtest, modeSample, modeClamp, modeHighz, testOverride},
          {2'b0, expModes(mActive)});
  endtask

  task automatic checkAll(input string tag);
    check({tag, " irSo"}, {7'b0, irSo}, {7'b0, mShift[0]});
    check({tag, " bypSo"}, {7'b0, bypSo}, {7'b0, mByp});
    checkModes({tag, " modes"});
  endtask

  // One edge of stimulus; model follows the requirements (R11 priority for reset)
  task automatic cyc(input logic t, input logic ci, input logic si, input logic ui,
                     input logic cd, input logic sd, input logic d);
    tlrIn = t; capIrIn = ci; shIrIn = si; updIrIn = ui; capDrIn = cd; shDrIn = sd; tdi = d;
    @(posedge tck);
    if (t) begin
      mShift = 8'b0011_1101; mActive = 8'hFF; mByp = 1'b0;
    end else begin
      if (ui) mActive = mShift;
      if (ci) mShift = 8'b0011_1101;
      else if (si) mShift = {d, mShift[7:1]};
      if (cd) mByp = 1'b0;
      else if (sd) mByp = d;
    end
    #1;
    tlrIn = 1'b0; capIrIn = 1'b0; shIrIn = 1'b0; updIrIn = 1'b0;
    capDrIn = 1'b0; shDrIn = 1'b0; tdi = 1'b0;
  endtask

  task automatic loadOp(input logic [7:0] op);
    cyc(0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      cyc(0, 0, 1, 0, 0, 0, op[i]);
      checkModes("R4 hold during shift");
    end
    cyc(0, 0, 0, 1, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] ops [6];
    int unsigned seed;
    ops[0] = 8'h00; ops[1] = 8'h81; ops[2] = 8'h82;
    ops[3] = 8'h03; ops[4] = 8'h5A; ops[5] = 8'hC1;
    seed = $urandom(32'd4242);

    repeat (3) cyc(1, 0, 0, 0, 0, 0, 0);
    checkAll("R1 reset");

    // R2 / R3: capture then read the pseudo-identifier LSB first
    cyc(0, 1, 0, 0, 0, 0, 0);
    check("R2 capture irSo", {7'b0, irSo}, 8'h01);
    for (int i = 0; i < 8; i++) begin
      check("R3 pattern bit", {7'b0, irSo}, {7'b0, 1'b0 ^ (8'b0011_1101 >> i) & 8'h01});
      cyc(0, 0, 1, 0, 0, 0, 1'b1);
    end
    check("R3 tdi reached bit 0", {7'b0, irSo}, 8'h01);
    checkModes("R4 no update yet");

    for (int k = 0; k < 6; k++) begin
      loadOp(ops[k]);
      checkModes(tagFor(ops[k]));
    end

    // R4: shift and capture without update leave the decode untouched
    loadOp(8'h82);
    cyc(0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0, 0, 0, 1'b0);
    checkModes("R4 clamp kept");

    // R10: bypass stage
    cyc(0, 0, 0, 0, 0, 1, 1);
    check("R10 shift one", {7'b0, bypSo}, 8'h01);
    cyc(0, 0, 0, 0, 1, 0, 1);
    check("R10 capture zero", {7'b0, bypSo}, 8'h00);
    cyc(0, 0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 1, 0);
    check("R10 shift zero", {7'b0, bypSo}, 8'h00);

    // R11: reset beats update and shift at the same edge
    loadOp(8'h00);
    checkModes("R5 before reset");
    cyc(0, 0, 1, 0, 0, 0, 0);
    cyc(1, 0, 1, 1, 0, 1, 1);
    checkAll("R11 reset priority");
    check("R11 bypass selected", {7'b0, selBypass}, 8'h01);

    // Random one-hot strobes with occasional reset
    for (int n = 0; n < 500; n++) begin
      int unsigned r;
      logic d;
      r = $urandom % 16;
      d = 1'($urandom);
      case (r)
        0:       cyc(1, 0, 0, 0, 0, 0, d);
        1, 2:    cyc(0, 1, 0, 0, 0, 0, d);
        3, 4, 5, 6: cyc(0, 0, 1, 0, 0, 0, d);
        7, 8:    cyc(0, 0, 0, 1, 0, 0, d);
        9:       cyc(0, 0, 0, 0, 1, 0, d);
        10, 11:  cyc(0, 0, 0, 0, 0, 1, d);
        default: cyc(0, 0, 0, 0, 0, 0, d);
      endcase
      checkAll("R3/R4/R10 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule